// File: doc/BRIEF.md
# TAP State-Walk Sequencer

This block drives a JTAG test access port through its state machine using movement commands instead of raw pin activity. A controller asks for three things in one command: an optional run of reset clocks, a destination (Run-Test/Idle, the instruction-register pause state or the data-register pause state), and a count of extra idle clocks. The sequencer turns the command into the exact TMS bit string, one TCK period per bit, while holding TDI low.

The block keeps one bit of memory about the target: whether the last move left it in Idle or in a Pause state. A move that starts from Pause first passes through Exit2 and Update before taking the usual route, so the same command yields different pin activity depending on what came before. A one-clock done pulse marks the end of each command, and a new command is taken only while the sequencer is not busy.

Top module: `tap_walk_seq`

## Requirements
- R1: After reset, tck and tms are low, done is low, cmd_ready is high, tdi is low and the tracked state is Idle.
- R2: A command is taken on a clock where cmd_valid and cmd_ready are both high; cmd_ready stays low from then until done, and cmd_valid pulses while cmd_ready is low start nothing and change no output.
- R3: Each TCK period is HALF_DIV clocks low followed by HALF_DIV clocks high; tms changes only while tck is low and the target samples it on the rising edge of tck.
- R4: With cmd_reset set, the first RESET_CYCLES (default 10) TCK periods carry TMS high; the reset run does not change the tracked state used to pick the path.
- R5: cmd_end selects the destination: 0 is Run-Test/Idle, 1 is IR pause, 2 is DR pause, and 3 is treated as Run-Test/Idle.
- R6: From Idle, the TMS string for the move is 1,1,0,1,0 toward IR pause, 1,0,1,0 toward DR pause and a single 0 toward Idle.
- R7: From a Pause state, every move is preceded by TMS 1,1 and then follows the same strings as in R6.
- R8: After the move, cmd_pad (0 to 255) further TCK periods follow with TMS low.
- R9: tdi stays low during every TCK period.
- R10: At the end of a command the tracked state becomes Pause if cmd_end was 1 or 2, and Idle otherwise.
- R11: done is high for exactly one clock, the clock right after the last falling edge of tck of the command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer can take a command |
| cmd_reset | input | 1 | Emit the TMS-high reset run first |
| cmd_end | input | 2 | Destination code (0 Idle, 1 IR pause, 2 DR pause, 3 Idle) |
| cmd_pad | input | PAD_W | Extra idle TCK periods after the move |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data in, held low |
| done | output | 1 | One-clock pulse when the command finishes |

## Verification
The bench walks every destination code, with and without the reset run, with no, one and several idle clocks, starting once from Idle and once from Pause, and compares the TMS string seen at each tck rise to a model built from the path rules. A sequencer that forgot the tracked state would miss the 1,1 prefix from Pause or add it from Idle; one that mishandled code 3 or a zero idle count would emit a wrong or extra period. A long 255-clock idle run exposes a counter that is too narrow, and a command offered while busy exposes a handshake that lets it in. Period widths and the position of done are measured on every command, so an off-by-one in the divider or a done raised one clock early shows up.

// File: rtl/tap_walk_pkg.sv
package tap_walk_pkg;

  // Destination codes carried on cmd_end.
  typedef enum logic [1:0] {
    END_RTI      = 2'd0,
    END_IR_PAUSE = 2'd1,
    END_DR_PAUSE = 2'd2,
    END_RTI_ALT  = 2'd3
  } end_code_e;

  // Segment of the command currently being emitted.
  typedef enum logic [1:0] {
    PH_RESET = 2'd0,
    PH_MOVE  = 2'd1,
    PH_PAD   = 2'd2
  } phase_e;

  // Longest move: Exit2, Update, then five steps to IR pause.
  localparam int unsigned PATH_MAX   = 7;
  localparam int unsigned PATH_LEN_W = 3;

endpackage

// File: rtl/tap_walk_path_lut.sv
module tap_walk_path_lut
  import tap_walk_pkg::*;
(
  input  logic                  from_pause,
  input  logic [1:0]            end_code,
  output logic [PATH_MAX-1:0]   path_bits,
  output logic [PATH_LEN_W-1:0] path_len
);

  // Bit 0 is emitted first.
  logic [4:0]            core_bits;
  logic [PATH_LEN_W-1:0] core_len;

  always_comb begin
    case (end_code)
      END_IR_PAUSE: begin core_bits = 5'b01011; core_len = 3'd5; end
      END_DR_PAUSE: begin core_bits = 5'b00101; core_len = 3'd4; end
      default:      begin core_bits = 5'b00000; core_len = 3'd1; end
    endcase
  end

  // Leaving a Pause state needs Exit2 and Update (two TMS ones) up front.
  always_comb begin
    if (from_pause) begin
      path_bits = {core_bits, 2'b11};
      path_len  = PATH_LEN_W'(core_len + 3'd2);
    end else begin
      path_bits = {2'b00, core_bits};
      path_len  = core_len;
    end
  end

endmodule

// File: rtl/tap_walk_tck_gen.sv
module tap_walk_tck_gen #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tck,
  output logic step_end
);

  localparam int unsigned PERIOD = 2 * HALF_DIV;
  localparam int unsigned CNT_W  = $clog2(PERIOD);
  localparam logic [CNT_W-1:0] RISE_AT = CNT_W'(HALF_DIV - 1);
  localparam logic [CNT_W-1:0] END_AT  = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tck_q, tck_d;

  always_comb begin
    cnt_d = cnt_q;
    tck_d = tck_q;
    if (!run) begin
      cnt_d = '0;
      tck_d = 1'b0;
    end else if (cnt_q == END_AT) begin
      cnt_d = '0;
      tck_d = 1'b0;
    end else begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == RISE_AT) tck_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tck_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tck_q <= tck_d;
    end
  end

  assign tck      = tck_q;
  assign step_end = run && (cnt_q == END_AT);

endmodule

// File: rtl/tap_walk_seq.sv
module tap_walk_seq
  import tap_walk_pkg::*;
#(
  parameter int unsigned HALF_DIV     = 2,
  parameter int unsigned RESET_CYCLES = 10,
  parameter int unsigned PAD_W        = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_reset,
  input  logic [1:0]       cmd_end,
  input  logic [PAD_W-1:0] cmd_pad,
  output logic             tck,
  output logic             tms,
  output logic             tdi,
  output logic             done
);

  localparam int unsigned RST_W   = $clog2(RESET_CYCLES) + 1;
  localparam int unsigned STEP_WA = (PAD_W > RST_W) ? PAD_W : RST_W;
  localparam int unsigned STEP_W  = (STEP_WA > PATH_LEN_W) ? STEP_WA : PATH_LEN_W;
  localparam logic [STEP_W-1:0] RST_LAST = STEP_W'(RESET_CYCLES - 1);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  // State.
  logic                  busy_q, busy_d;
  phase_e                phase_q, phase_d;
  logic [STEP_W-1:0]     idx_q, idx_d;
  logic [1:0]            end_q, end_d;
  logic [PAD_W-1:0]      pad_q, pad_d;
  logic                  pause_q, pause_d;
  logic                  done_q, done_d;
  logic [PATH_MAX-1:0]   path_q, path_d;
  logic [PATH_LEN_W-1:0] plen_q, plen_d;

  logic                  step_end;
  logic                  accept;
  logic                  finish;
  logic [PATH_MAX-1:0]   lut_bits;
  logic [PATH_LEN_W-1:0] lut_len;
  logic [PATH_MAX-1:0]   path_shift;

  tap_walk_path_lut u_lut (
    .from_pause (pause_q),
    .end_code   (cmd_end),
    .path_bits  (lut_bits),
    .path_len   (lut_len)
  );

  tap_walk_tck_gen #(.HALF_DIV(HALF_DIV)) u_tck (
    .clk      (clk),
    .rst_n    (srst_n),
    .run      (busy_q),
    .tck      (tck),
    .step_end (step_end)
  );

  assign accept = cmd_valid && !busy_q;

  // Next state.
  always_comb begin
    busy_d  = busy_q;
    phase_d = phase_q;
    idx_d   = idx_q;
    end_d   = end_q;
    pad_d   = pad_q;
    pause_d = pause_q;
    path_d  = path_q;
    plen_d  = plen_q;
    done_d  = 1'b0;
    finish  = 1'b0;

    if (accept) begin
      busy_d  = 1'b1;
      end_d   = cmd_end;
      pad_d   = cmd_pad;
      path_d  = lut_bits;
      plen_d  = lut_len;
      idx_d   = '0;
      phase_d = cmd_reset ? PH_RESET : PH_MOVE;
    end else if (busy_q && step_end) begin
      case (phase_q)
        PH_RESET: begin
          if (idx_q == RST_LAST) begin
            phase_d = PH_MOVE;
            idx_d   = '0;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
        PH_MOVE: begin
          if (idx_q == STEP_W'(plen_q) - STEP_W'(1)) begin
            if (pad_q == '0) begin
              finish = 1'b1;
            end else begin
              phase_d = PH_PAD;
              idx_d   = '0;
            end
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
        default: begin
          if (idx_q == STEP_W'(pad_q) - STEP_W'(1)) finish = 1'b1;
          else                                      idx_d  = idx_q + 1'b1;
        end
      endcase
    end

    if (finish) begin
      busy_d  = 1'b0;
      done_d  = 1'b1;
      pause_d = (end_q == END_IR_PAUSE) || (end_q == END_DR_PAUSE);
    end
  end

  // Registers.
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      busy_q  <= 1'b0;
      phase_q <= PH_MOVE;
      idx_q   <= '0;
      end_q   <= 2'b00;
      pad_q   <= '0;
      pause_q <= 1'b0;
      done_q  <= 1'b0;
      path_q  <= '0;
      plen_q  <= '0;
    end else begin
      busy_q  <= busy_d;
      phase_q <= phase_d;
      idx_q   <= idx_d;
      end_q   <= end_d;
      pad_q   <= pad_d;
      pause_q <= pause_d;
      done_q  <= done_d;
      path_q  <= path_d;
      plen_q  <= plen_d;
    end
  end

  // Outputs. Phase and index move only on the edge where tck falls.
  assign path_shift = path_q >> idx_q[PATH_LEN_W-1:0];

  always_comb begin
    tms = 1'b0;
    if (busy_q) begin
      case (phase_q)
        PH_RESET: tms = 1'b1;
        PH_MOVE:  tms = path_shift[0];
        default:  tms = 1'b0;
      endcase
    end
  end

  assign tdi       = 1'b0;
  assign cmd_ready = !busy_q;
  assign done      = done_q;

  // Checks.
  p_tms_quiet_high_r3: assert property (@(posedge clk) disable iff (!srst_n)
    (tck && $past(tck)) |-> $stable(tms));

  p_done_single_r11: assert property (@(posedge clk) disable iff (!srst_n)
    done |=> !done);

  p_done_after_fall_r11: assert property (@(posedge clk) disable iff (!srst_n)
    done |-> (!tck && $past(tck)));

  p_tck_parked_r2: assert property (@(posedge clk) disable iff (!srst_n)
    cmd_ready |-> !tck);

  p_track_on_done_r10: assert property (@(posedge clk) disable iff (!srst_n)
    !$stable(pause_q) |-> done);

endmodule

// File: tb/tb_tap_walk_seq.sv
module tb_tap_walk_seq;

  localparam int HALF = 2;
  localparam int RSTC = 10;
  localparam int MAXN = 400;

  logic       clk;
  logic       rst_n;
  logic       cmd_valid;
  logic       cmd_ready;
  logic       cmd_reset;
  logic [1:0] cmd_end;
  logic [7:0] cmd_pad;
  logic       tck;
  logic       tms;
  logic       tdi;
  logic       done;

  tap_walk_seq #(.HALF_DIV(HALF), .RESET_CYCLES(RSTC), .PAD_W(8)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_reset (cmd_reset),
    .cmd_end   (cmd_end),
    .cmd_pad   (cmd_pad),
    .tck       (tck),
    .tms       (tms),
    .tdi       (tdi),
    .done      (done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  int obs_tms [MAXN];
  int obs_n      = 0;
  int obs_tdi_hi = 0;
  int exp_tms [MAXN];
  int exp_n      = 0;
  int seg_rst    = 0;
  int seg_pre    = 0;
  int seg_move   = 0;

  int hi_run = 0, lo_run = 0, timing_err = 0, tms_hi_chg = 0;
  int done_seen = 0, done_wide = 0, done_bad_pos = 0;
  logic prev_tck = 1'b0, prev_tms = 1'b0, prev_done = 1'b0;
  bit model_pause = 1'b0;

  task automatic chk(input bit ok, input string req, input int act,
                     input int expv, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Observer: sampled away from the active edge.
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (tck && !prev_tck) begin
        if (obs_n < MAXN) obs_tms[obs_n] = int'(tms);
        if (tdi) obs_tdi_hi++;
        obs_n++;
        if (lo_run != HALF) timing_err++;
        lo_run = 0;
      end
      if (!tck && prev_tck) begin
        if (hi_run != HALF) timing_err++;
        hi_run = 0;
        lo_run = 0;
      end
      if (tck) begin
        hi_run++;
        if (prev_tck && (tms != prev_tms)) tms_hi_chg++;
      end else if (!cmd_ready) begin
        lo_run++;
      end
      if (done) begin
        done_seen++;
        if (prev_done) done_wide++;
        if (!prev_tck || tck) done_bad_pos++;
      end
    end
    prev_tck  = tck;
    prev_tms  = tms;
    prev_done = done;
  end

  task automatic summary_and_end();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(negedge clk) begin
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL R2 watchdog: actual=%0d expected=<150000 cycles", cyc);
      summary_and_end();
    end
  end

  task automatic push(input int v);
    exp_tms[exp_n] = v;
    exp_n++;
  endtask

  // Expected TMS string from the path rules.
  task automatic build_exp(input bit r, input int e, input int pad, input bit from_pause);
    exp_n = 0;
    if (r) for (int i = 0; i < RSTC; i++) push(1);
    seg_rst = exp_n;
    if (from_pause) begin push(1); push(1); end
    seg_pre = exp_n;
    if (e == 1) begin push(1); push(1); push(0); push(1); push(0); end
    else if (e == 2) begin push(1); push(0); push(1); push(0); end
    else push(0);
    seg_move = exp_n;
    for (int i = 0; i < pad; i++) push(0);
  endtask

  function automatic string tag_for(input int idx);
    if (idx < seg_rst) return "R4";
    if (idx < seg_pre) return "R7 R10";
    if (idx < seg_move) return model_pause ? "R5 R7" : "R5 R6";
    return "R8";
  endfunction

  task automatic start_cmd(input bit r, input int e, input int pad);
    build_exp(r, e, pad, model_pause);
    obs_n = 0; obs_tdi_hi = 0; timing_err = 0; tms_hi_chg = 0;
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1;
    cmd_reset = r;
    cmd_end   = 2'(e);
    cmd_pad   = 8'(pad);
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_reset = 1'b0;
    cmd_end   = 2'd0;
    cmd_pad   = 8'd0;
    chk(!cmd_ready, "R2", int'(cmd_ready), 0, "ready after accept");
  endtask

  task automatic finish_cmd(input int e, input int d0);
    int bad;
    while (done_seen == d0) @(negedge clk);
    @(negedge clk);
    chk(obs_n == exp_n, "R5 R8", obs_n, exp_n, "TCK period count");
    bad = -1;
    for (int i = 0; i < exp_n && i < obs_n; i++)
      if (bad < 0 && obs_tms[i] != exp_tms[i]) bad = i;
    if (bad >= 0)
      chk(1'b0, tag_for(bad), obs_tms[bad], exp_tms[bad],
          $sformatf("TMS at period %0d", bad));
    else
      chk(1'b1, "R6 R7", 0, 0, "TMS string");
    chk(obs_tdi_hi == 0, "R9", obs_tdi_hi, 0, "TDI high periods");
    chk(timing_err == 0 && tms_hi_chg == 0, "R3", timing_err + tms_hi_chg, 0,
        "half-period or TMS-while-high errors");
    chk(done_seen == d0 + 1 && done_wide == 0 && done_bad_pos == 0, "R11",
        done_seen - d0 + 10 * (done_wide + done_bad_pos), 1, "done pulse");
    model_pause = (e == 1) || (e == 2);
  endtask

  task automatic run_cmd(input bit r, input int e, input int pad);
    int d0;
    d0 = done_seen;
    start_cmd(r, e, pad);
    finish_cmd(e, d0);
  endtask

  initial begin
    int d0;
    int n_before;
    rst_n     = 1'b0;
    cmd_valid = 1'b0;
    cmd_reset = 1'b0;
    cmd_end   = 2'd0;
    cmd_pad   = 8'd0;
    repeat (5) @(negedge clk);
    chk(tck == 1'b0, "R1", int'(tck), 0, "tck in reset");
    chk(tms == 1'b0, "R1", int'(tms), 0, "tms in reset");
    chk(done == 1'b0, "R1", int'(done), 0, "done in reset");
    chk(tdi == 1'b0, "R1", int'(tdi), 0, "tdi in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cmd_ready == 1'b1, "R1", int'(cmd_ready), 1, "ready after reset");

    // R1: first move is taken from Idle.
    run_cmd(1'b0, 2, 0);

    // Sweep start state, reset flag, destination code and idle count.
    for (int sp = 0; sp < 2; sp++)
      for (int r = 0; r < 2; r++)
        for (int e = 0; e < 4; e++)
          for (int pi = 0; pi < 3; pi++) begin
            int p;
            p = (pi == 0) ? 0 : ((pi == 1) ? 1 : 3);
            if (sp == 1) run_cmd(1'b0, 1 + (p % 2), 0);
            else         run_cmd(1'b0, (e == 0) ? 3 : 0, 0);
            run_cmd(r[0], e, p);
          end

    // R8: longest idle run.
    run_cmd(1'b0, 0, 255);

    // R2: a command offered while busy is ignored.
    d0 = done_seen;
    start_cmd(1'b0, 2, 2);
    repeat (6) @(negedge clk);
    chk(!cmd_ready, "R2", int'(cmd_ready), 0, "ready while busy");
    cmd_valid = 1'b1; cmd_reset = 1'b1; cmd_end = 2'd1; cmd_pad = 8'd9;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_reset = 1'b0; cmd_end = 2'd0; cmd_pad = 8'd0;
    finish_cmd(2, d0);
    n_before = obs_n;
    repeat (30) @(negedge clk);
    chk(obs_n == n_before, "R2", obs_n, n_before, "periods after ignored command");
    chk(cmd_ready && done_seen == d0 + 1, "R2", done_seen - d0, 1, "no extra command run");

    // R10: the previous move ended in DR pause, so this one needs the prefix.
    run_cmd(1'b1, 0, 1);

    summary_and_end();
  end

endmodule